// File: doc/BRIEF.md
# Last-Outcome Branch Predictor with Static Fallback

This block gives a taken or not-taken guess for a branch in the same cycle in which the branch is presented. The front end supplies the branch address and two qualifiers: whether the branch is unconditional, and whether its target lies at a lower address than the branch itself. Unconditional branches are always guessed taken. For a conditional branch, a small direct-mapped, tagged table is consulted. If the table holds that branch, the guess repeats the outcome it had the last time it resolved. If the table does not hold it, a fixed rule applies: a branch that jumps backward is guessed taken, and one that jumps forward is guessed not taken.

When a conditional branch resolves, the back end reports its address and actual outcome on the resolve port. That write replaces the slot selected by the low address bits, whatever that slot held before. Two branches whose addresses share those low bits therefore evict each other. Both ports are plain strobed inputs. The lookup is purely combinational. A resolve is always accepted and takes effect at the next rising clock edge, so the block never applies back-pressure.

Top module: `lastout_predictor`

## Requirements
- R1: A valid lookup with `lk_uncond`=1 drives `pred_taken`=1, whatever the table holds.
- R2: A valid conditional lookup that hits in the table drives `pred_taken` equal to the outcome most recently written for that slot.
- R3: A valid conditional lookup that misses drives `pred_taken`=`lk_backward`, so backward is taken and forward is not taken.
- R4: The table has 2^IDX_W slots (16 by default). A slot is selected by address bits [IDX_W-1:0] and tagged with bits [ADDR_W-1:IDX_W]. A resolve writes the selected slot with the new tag, sets it valid and stores the outcome. This replaces any earlier branch in that slot, so the earlier branch then misses.
- R5: When a resolve and a lookup of the same address occur in the same cycle, the lookup sees the table contents from before that resolve. The resolve becomes visible from the next cycle on.
- R6: Reset (`rst_n`=0) invalidates every slot, so every conditional lookup after reset follows the R3 rule until it is resolved again.
- R7: `pred_hit` is 1 exactly when a valid lookup finds a valid slot whose tag matches. This holds for unconditional lookups as well.
- R8: While `lk_valid`=0, `pred_taken` and `pred_hit` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_addr | input | ADDR_W | Address of the branch being predicted |
| lk_uncond | input | 1 | 1 = unconditional branch |
| lk_backward | input | 1 | 1 = target lies at a lower address |
| pred_taken | output | 1 | Predicted direction, combinational |
| pred_hit | output | 1 | Lookup matched a valid tagged slot |
| rs_valid | input | 1 | Resolve strobe for a conditional branch |
| rs_addr | input | ADDR_W | Address of the resolved branch |
| rs_taken | input | 1 | Actual outcome of the resolved branch |

## Verification
The prediction and hit outputs are due in the same cycle as the lookup. The bench therefore drives every lookup on the falling edge and samples both outputs shortly afterwards, before the next rising edge. A resolve is due one rising edge after it is driven. The bench's reference table is updated only after that edge, so lookups in the resolve cycle are compared against the old contents, as R5 requires. Reset clearing is checked on the first lookups after reset is released, both at start-up and after a second reset in the middle of the run.

// File: rtl/bp_pkg.sv
package bp_pkg;

  typedef enum logic [1:0] {
    SRC_IDLE    = 2'd0,
    SRC_ALWAYS  = 2'd1,
    SRC_HISTORY = 2'd2,
    SRC_STATIC  = 2'd3
  } pred_src_e;

  function automatic pred_src_e pick_source(input logic valid,
                                            input logic uncond,
                                            input logic hit);
    if (!valid)      return SRC_IDLE;
    else if (uncond) return SRC_ALWAYS;
    else if (hit)    return SRC_HISTORY;
    else             return SRC_STATIC;
  endfunction

endpackage

// File: rtl/bp_static_rule.sv
module bp_static_rule (
  input  logic uncond,
  input  logic backward,
  output logic static_taken
);
  // Fallback direction rule: unconditional or backward targets go taken.
  assign static_taken = uncond | backward;
endmodule

// File: rtl/bp_hist_table.sv
module bp_hist_table #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_hit,
  output logic              rd_taken,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_taken
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [DEPTH-1:0] valid_q;
  logic [DEPTH-1:0] out_q;
  logic [TAG_W-1:0] tag_q [DEPTH];

  logic [IDX_W-1:0] rd_idx, wr_idx;
  logic [TAG_W-1:0] rd_tag, wr_tag;

  assign rd_idx = rd_addr[IDX_W-1:0];
  assign rd_tag = rd_addr[ADDR_W-1:IDX_W];
  assign wr_idx = wr_addr[IDX_W-1:0];
  assign wr_tag = wr_addr[ADDR_W-1:IDX_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      out_q[wr_idx] <= wr_taken;
      tag_q[wr_idx] <= wr_tag;
    end
  end

  // Read side uses the registered contents, so a same-cycle write is not seen.
  assign rd_hit   = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
  assign rd_taken = out_q[rd_idx];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (valid_q[$past(wr_idx)] && (out_q[$past(wr_idx)] == $past(wr_taken))
               && (tag_q[$past(wr_idx)] == $past(wr_tag)))); // R4

  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rst_n |-> (valid_q == '0)); // R6

endmodule

// File: rtl/lastout_predictor.sv
module lastout_predictor #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              lk_uncond,
  input  logic              lk_backward,
  output logic              pred_taken,
  output logic              pred_hit,
  input  logic              rs_valid,
  input  logic [ADDR_W-1:0] rs_addr,
  input  logic              rs_taken
);
  import bp_pkg::*;

  logic      tbl_hit, tbl_taken, fallback_taken;
  pred_src_e src;

  bp_hist_table #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_addr  (lk_addr),
    .rd_hit   (tbl_hit),
    .rd_taken (tbl_taken),
    .wr_en    (rs_valid),
    .wr_addr  (rs_addr),
    .wr_taken (rs_taken)
  );

  bp_static_rule u_static (
    .uncond       (lk_uncond),
    .backward     (lk_backward),
    .static_taken (fallback_taken)
  );

  always_comb begin
    src = pick_source(lk_valid, lk_uncond, tbl_hit);
    unique case (src)
      SRC_IDLE:    pred_taken = 1'b0;
      SRC_ALWAYS:  pred_taken = 1'b1;
      SRC_HISTORY: pred_taken = tbl_taken;
      SRC_STATIC:  pred_taken = fallback_taken;
      default:     pred_taken = 1'b0;
    endcase
  end

  assign pred_hit = lk_valid & tbl_hit;

  AST_UNCOND_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_uncond) |-> pred_taken); // R1

  AST_MISS_STATIC: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !lk_uncond && !pred_hit) |-> (pred_taken == lk_backward)); // R3

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> (!pred_taken && !pred_hit)); // R8

  AST_RESOLVE_THEN_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && lk_valid && !lk_uncond && (lk_addr == rs_addr)) |=>
      (($past(lk_addr) != lk_addr) || !lk_valid || lk_uncond
       || (pred_hit && (pred_taken == $past(rs_taken))))); // R2

endmodule

// File: tb/test_lastout_predictor.sv
module test_lastout_predictor;
  localparam int ADDR_W = 32;
  localparam int IDX_W  = 4;
  localparam int DEPTH  = 1 << IDX_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 1'b0, lk_uncond = 1'b0, lk_backward = 1'b0;
  logic [ADDR_W-1:0] lk_addr = '0, rs_addr = '0;
  logic rs_valid = 1'b0, rs_taken = 1'b0;
  logic pred_taken, pred_hit;

  int checks = 0;
  int errors = 0;

  // Reference table
  logic                    m_valid [DEPTH];
  logic [ADDR_W-IDX_W-1:0] m_tag   [DEPTH];
  logic                    m_out   [DEPTH];

  always #10 clk = ~clk;

  lastout_predictor #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_lastout_predictor (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_uncond(lk_uncond),
    .lk_backward(lk_backward), .pred_taken(pred_taken), .pred_hit(pred_hit),
    .rs_valid(rs_valid), .rs_addr(rs_addr), .rs_taken(rs_taken)
  );

  task automatic model_clear();
    for (int i = 0; i < DEPTH; i++) begin
      m_valid[i] = 1'b0; m_tag[i] = '0; m_out[i] = 1'b0;
    end
  endtask

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  // One cycle: drive at falling edge, check outputs, then let the edge apply the resolve.
  task automatic step(input logic lv, input logic [ADDR_W-1:0] la, input logic lu,
                      input logic lb, input logic rv, input logic [ADDR_W-1:0] ra,
                      input logic rt, input string req);
    logic [IDX_W-1:0] idx;
    logic eh, et;
    lk_valid = lv; lk_addr = la; lk_uncond = lu; lk_backward = lb;
    rs_valid = rv; rs_addr = ra; rs_taken = rt;
    #2;
    idx = la[IDX_W-1:0];
    eh = lv && m_valid[idx] && (m_tag[idx] == la[ADDR_W-1:IDX_W]);
    if (!lv)      et = 1'b0;
    else if (lu)  et = 1'b1;
    else if (eh)  et = m_out[idx];
    else          et = lb;
    if (lv || req == "R8") begin
      check(req, "pred_taken", pred_taken, et);
      check(req, "pred_hit", pred_hit, eh);
    end
    @(posedge clk);
    if (rv) begin
      m_valid[ra[IDX_W-1:0]] = 1'b1;
      m_tag[ra[IDX_W-1:0]]   = ra[ADDR_W-1:IDX_W];
      m_out[ra[IDX_W-1:0]]   = rt;
    end
    @(negedge clk);
    lk_valid = 1'b0; rs_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    model_clear();
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    // R6: every slot empty, conditional lookups fall back to direction rule
    for (int i = 0; i < 4; i++) begin
      step(1, 32'h1000 + 32'(i) * 4, 0, i[0], 0, '0, 0, "R6");
    end
  endtask

  task automatic t_uncond();
    // R1: unconditional always taken, even if the slot says not taken; R7 hit still reported
    step(1, 32'h2004, 1, 0, 0, '0, 0, "R1");
    step(0, '0, 0, 0, 1, 32'h2004, 0, "R1");
    step(1, 32'h2004, 1, 0, 0, '0, 0, "R7");
    step(1, 32'h2004, 0, 1, 0, '0, 0, "R2");
  endtask

  task automatic t_static();
    // R3: misses follow direction
    step(1, 32'h3007, 0, 1, 0, '0, 0, "R3");
    step(1, 32'h3007, 0, 0, 0, '0, 0, "R3");
  endtask

  task automatic t_loop();
    // R2: loop branch, backward, taken several times then exits
    for (int i = 0; i < 5; i++) step(1, 32'h40A8, 0, 1, 1, 32'h40A8, 1, "R2");
    step(1, 32'h40A8, 0, 1, 1, 32'h40A8, 0, "R2");
    step(1, 32'h40A8, 0, 1, 0, '0, 0, "R2");
    // forward branch resolved taken then predicted taken
    step(0, '0, 0, 0, 1, 32'h5001, 1, "R2");
    step(1, 32'h5001, 0, 0, 0, '0, 0, "R2");
  endtask

  task automatic t_alias();
    // R4: 0x6003 and 0x6013 share slot 3; second evicts first
    step(0, '0, 0, 0, 1, 32'h6003, 0, "R4");
    step(1, 32'h6003, 0, 1, 0, '0, 0, "R4");
    step(1, 32'h6013, 0, 1, 0, '0, 0, "R4");
    step(0, '0, 0, 0, 1, 32'h6013, 1, "R4");
    step(1, 32'h6003, 0, 0, 0, '0, 0, "R4");
    step(1, 32'h6013, 0, 0, 0, '0, 0, "R4");
  endtask

  task automatic t_same_cycle();
    // R5: same-cycle resolve invisible to lookup, visible next cycle
    step(1, 32'h700C, 0, 1, 1, 32'h700C, 0, "R5");
    step(1, 32'h700C, 0, 1, 1, 32'h700C, 1, "R5");
    step(1, 32'h700C, 0, 0, 0, '0, 0, "R5");
  endtask

  task automatic t_idle();
    // R8: no lookup, outputs low even with a matching slot present
    step(0, 32'h700C, 1, 1, 0, '0, 0, "R8");
    step(0, 32'h40A8, 0, 1, 1, 32'h40A8, 1, "R8");
  endtask

  task automatic t_reset_again();
    // R6: mid-run reset drops stored history
    do_reset();
    step(1, 32'h700C, 0, 0, 0, '0, 0, "R6");
    step(1, 32'h5001, 0, 0, 0, '0, 0, "R6");
  endtask

  initial begin
    model_clear();
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_uncond();
    t_static();
    t_loop();
    t_alias();
    t_same_cycle();
    t_idle();
    t_reset_again();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule